// File: doc/BRIEF.md
# Programmable Self-Synchronizing Scrambler

This block whitens a serial bit stream before transmission and restores it on reception. It keeps a seven-stage history of the scrambled line stream. On every accepted bit it folds the history stages picked by a runtime tap mask into one parity bit, and it XORs that parity with the incoming bit. The same structure serves both directions. In scramble mode the produced (line) bit enters the history. In descramble mode the received line bit enters the history. Because of this, a receiver locks onto any transmitter after seven bits, with no seed exchange. The block treats preamble, header and payload the same way.

A mask of all zeros turns the block into a one-cycle delay line. With the usual mask (delays 4 and 7, polynomial x^7 + x^4 + 1), certain repetitive inputs can settle into an unscrambled steady state. Examples are a zero history fed zeros, or a history of ones fed ones. Any break in the pattern starts scrambling again.

Top module: `sss_scrambler`

## Requirements
- R1: While `rst` is high at a rising edge, the history and both outputs clear to 0. So the first bit after reset sees an all-zero history.
- R2: Each bit accepted with `in_vld` high appears on `out_bit` with `out_vld` high exactly one clock later. `out_vld` is low in the cycle after an idle input cycle.
- R3: The history advances only on cycles with `in_vld` high. Idle cycles leave later outputs unchanged.
- R4: Scramble mode (`mode`=0): out = in XOR parity(hist AND tap_mask). The produced bit is shifted into the history.
- R5: Descramble mode (`mode`=1): out = in XOR parity(hist AND tap_mask). The received input bit is shifted into the history.
- R6: In the history, bit k-1 is the line bit from k accepted bits ago. Bit k-1 of `tap_mask` enables the tap at delay k, so the usual setting is 7'h48. When `tap_mask` is 0, out equals in, in both modes.
- R7: A descrambler with the same mask recovers every scrambler input bit once seven line bits have passed, whatever its starting history.
- R8: A change of `tap_mask` takes effect on the next accepted bit.
- R9: With mask 7'h48, a zero history fed zeros gives zero output. A single 1 in the input then produces further 1s on the output while zeros follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input bit strobe |
| in_bit | input | 1 | Serial input bit |
| mode | input | 1 | 0 = scramble, 1 = descramble |
| tap_mask | input | 7 | Tap enables, bit k-1 = delay k |
| out_vld | output | 1 | Output bit strobe |
| out_bit | output | 1 | Serial output bit |

## Verification
A wrong history bit shows up as a flipped `out_bit` on the first accepted bit whose mask taps that stage. That is at most seven accepted bits after the fault, and one clock later at the port. A history that moves on idle cycles, or that takes in the wrong source bit for its mode, shifts every later parity. The bench compares every output bit against an independent bit-level model. A second instance acting as receiver confirms that the original data is recovered from an arbitrary start.

// File: rtl/sss_pkg.sv
package sss_pkg;

    localparam int unsigned SSS_DEF_LEN = 7;

    typedef enum logic {
        MODE_SCRAMBLE   = 1'b0,
        MODE_DESCRAMBLE = 1'b1
    } sss_mode_e;

    typedef struct packed {
        logic vld;
        logic dat;
    } sss_beat_t;

    // choose which bit enters the history for the given direction
    function automatic logic hist_source(input sss_mode_e m, input logic rx_bit, input logic line_bit);
        return (m == MODE_DESCRAMBLE) ? rx_bit : line_bit;
    endfunction

endpackage

// File: rtl/sss_tap_xor.sv
module sss_tap_xor #(
    parameter int unsigned LEN = 7
) (
    input  logic [LEN-1:0] hist,
    input  logic [LEN-1:0] mask,
    output logic           fb
);
    logic [LEN:0] acc;

    assign acc[0] = 1'b0;
    for (genvar g = 0; g < LEN; g++) begin : g_tap
        assign acc[g+1] = acc[g] ^ (hist[g] & mask[g]);
    end
    assign fb = acc[LEN];
endmodule

// File: rtl/sss_hist_reg.sv
module sss_hist_reg #(
    parameter int unsigned LEN = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    input  logic           shift_in,
    output logic [LEN-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (adv) begin
            hist <= {hist[LEN-2:0], shift_in};
        end
    end
endmodule

// File: rtl/sss_out_stage.sv
module sss_out_stage
    import sss_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sss_beat_t nxt,
    output sss_beat_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/sss_scrambler.sv
module sss_scrambler
    import sss_pkg::*;
#(
    parameter int unsigned LEN = SSS_DEF_LEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic           in_bit,
    input  logic           mode,
    input  logic [LEN-1:0] tap_mask,
    output logic           out_vld,
    output logic           out_bit
);
    sss_mode_e      mode_e;
    logic [LEN-1:0] hist_q;
    logic           parity;
    logic           line_bit;
    logic           enter_bit;
    sss_beat_t      beat_d;
    sss_beat_t      beat_q;

    assign mode_e = sss_mode_e'(mode);

    sss_tap_xor #(.LEN(LEN)) u_taps (
        .hist (hist_q),
        .mask (tap_mask),
        .fb   (parity)
    );

    assign line_bit  = in_bit ^ parity;
    assign enter_bit = hist_source(mode_e, in_bit, line_bit);

    sss_hist_reg #(.LEN(LEN)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_vld),
        .shift_in (enter_bit),
        .hist     (hist_q)
    );

    always_comb begin
        beat_d.vld = in_vld;
        beat_d.dat = in_vld ? line_bit : 1'b0;
    end

    sss_out_stage u_out (
        .clk (clk),
        .rst (rst),
        .nxt (beat_d),
        .q   (beat_q)
    );

    assign out_vld = beat_q.vld;
    assign out_bit = beat_q.dat;
endmodule

// File: rtl/sss_scrambler_chk.sv
module sss_scrambler_chk #(
    parameter int unsigned LEN = 7
) (
    input logic           clk,
    input logic           rst,
    input logic           in_vld,
    input logic           in_bit,
    input logic           mode,
    input logic [LEN-1:0] tap_mask,
    input logic           out_vld,
    input logic           out_bit,
    input logic [LEN-1:0] hist
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (hist == '0 && !out_vld && !out_bit));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R3
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(hist));

    // R4
    tx_feeds_line_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !mode) |=> (hist[0] == out_bit));

    // R5
    rx_feeds_input_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode) |=> (hist[0] == $past(in_bit)));

    // R6
    zero_mask_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && tap_mask == '0) |=> (out_bit == $past(in_bit)));
endmodule

bind sss_scrambler sss_scrambler_chk #(.LEN(LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_bit   (in_bit),
    .mode     (mode),
    .tap_mask (tap_mask),
    .out_vld  (out_vld),
    .out_bit  (out_bit),
    .hist     (hist_q)
);

// File: tb/sss_scrambler_tb.sv
module sss_scrambler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN = 7;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_vld = 1'b0;
    logic           in_bit = 1'b0;
    logic           mode = 1'b0;
    logic [LEN-1:0] tap_mask = 7'h48;
    logic           out_vld;
    logic           out_bit;
    logic           rx_vld;
    logic           rx_bit;

    int n_cmp = 0;
    int n_bad = 0;
    logic [LEN-1:0] m_hist = '0;
    logic [15:0]    rnd = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sss_scrambler #(.LEN(LEN)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit), .mode(mode),
        .tap_mask(tap_mask), .out_vld(out_vld), .out_bit(out_bit)
    );

    // receiver fed from the transmitter line
    sss_scrambler #(.LEN(LEN)) u_rx (
        .clk(clk), .rst(rst), .in_vld(out_vld), .in_bit(out_bit), .mode(1'b1),
        .tap_mask(tap_mask), .out_vld(rx_vld), .out_bit(rx_bit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic next_rnd();
        rnd = {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
        return rnd[0];
    endfunction

    // one clock: drive, update model, check output at the next falling edge
    task automatic step(input logic v, input logic d, input string tag);
        logic y;
        y = d ^ (^(m_hist & tap_mask));
        in_vld = v;
        in_bit = d;
        if (v) m_hist = {m_hist[LEN-2:0], (mode ? d : y)};
        @(negedge clk);
        chk(out_vld == v, {tag, " R2 out_vld"}, int'(out_vld), int'(v));
        if (v) chk(out_bit == y, {tag, " out_bit"}, int'(out_bit), int'(y));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_hist = '0;
        chk(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
        chk(out_bit == 1'b0, "R1 out_bit after reset", int'(out_bit), 0);
    endtask

    task automatic t_reset_history();
        t_reset();
        tap_mask = 7'h7F; mode = 1'b0;
        step(1'b1, 1'b0, "R1 zero history first bit");
        step(1'b0, 1'b0, "R1 idle");
    endtask

    task automatic t_scramble();
        tap_mask = 7'h48; mode = 1'b0;
        for (int i = 0; i < 80; i++) step(1'b1, next_rnd(), "R4 scramble");
        tap_mask = 7'h11;
        for (int i = 0; i < 40; i++) step(1'b1, next_rnd(), "R4 scramble alt mask");
    endtask

    task automatic t_descramble();
        tap_mask = 7'h48; mode = 1'b1;
        for (int i = 0; i < 80; i++) step(1'b1, next_rnd(), "R5 descramble");
    endtask

    task automatic t_passthrough();
        tap_mask = '0;
        for (int md = 0; md < 2; md++) begin
            mode = md[0];
            for (int i = 0; i < 30; i++) step(1'b1, next_rnd(), "R6 zero mask");
        end
    endtask

    task automatic t_gaps();
        tap_mask = 7'h48; mode = 1'b0;
        for (int i = 0; i < 60; i++) begin
            step(1'b1, next_rnd(), "R3 gapped");
            if (rnd[2]) step(1'b0, next_rnd(), "R3 idle");
        end
    endtask

    task automatic t_mask_change();
        mode = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tap_mask = rnd[LEN-1:0];
            step(1'b1, next_rnd(), "R8 mask change");
        end
    endtask

    task automatic t_roundtrip();
        logic sent [0:95];
        tap_mask = 7'h48; mode = 1'b0;
        for (int i = 0; i < 96; i++) begin
            sent[i] = next_rnd();
            step(1'b1, sent[i], "R7 tx");
            if (i >= 8) chk(rx_vld && rx_bit == sent[i-1], "R7 recovered",
                            int'(rx_bit), int'(sent[i-1]));
        end
    endtask

    task automatic t_lockup();
        int ones;
        t_reset();
        tap_mask = 7'h48; mode = 1'b0;
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, "R9 zero lock");
            ones += int'(out_bit);
        end
        chk(ones == 0, "R9 zeros stay unscrambled", ones, 0);
        step(1'b1, 1'b1, "R9 break");
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, "R9 restart");
            ones += int'(out_bit);
        end
        chk(ones >= 2, "R9 scrambling resumes", ones, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_history();
        t_scramble();
        t_descramble();
        t_passthrough();
        t_gaps();
        t_mask_change();
        t_roundtrip();
        t_lockup();
        in_vld = 1'b0;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule